// File: doc/BRIEF.md
# Locality-Aware Page State Tracker for a Write-Limited Memory Tier

This block holds the replacement state for every page frame of the slow, write-limited tier of a two-tier main memory. Each frame keeps a reference flag, a bitmap with one dirty flag per sub-block, and a saturating dirty counter. The memory controller reports hits on the tier (page, sub-block, read or write), reports pages that it moves into the tier by demotion from the fast tier, and asks for an eviction victim when the tier is full.

A write to a sub-block that has not been written before counts as spatial locality: the flag is set and the counter grows. A write to a sub-block that is already dirty counts as temporal locality and raises a one-cycle promotion pulse carrying the page index, so the controller can swap that page with the fast tier. Victim search is a clock sweep that visits one frame per cycle, ageing the reference flag and the counter, and stops on the first frame with both at zero. The data movement itself lives outside this block.

Top module: `pcm_page_tracker`

## Requirements
- R1: After reset, promote_o and done_o are 0, every frame has its reference flag, bitmap and counter clear, and the sweep hand points at frame 0, so the first victim request returns frame 0 after one visit.
- R2: Any hit, read or write, sets the reference flag of the frame; a read hit changes neither the bitmap nor the counter.
- R3: A write hit to a sub-block whose dirty flag is 0 sets that flag and increments the counter, saturating at its maximum, with no promotion pulse; the counter never exceeds the number of dirty flags set.
- R4: A write hit to a sub-block whose dirty flag is already 1 drives promote_o high with promote_page_o equal to the hit page in the cycle after the hit, for exactly one cycle.
- R5: An insert loads the frame's reference flag from ins_ref_i and clears its bitmap and counter; an insert overrides a hit to the same frame in the same cycle.
- R6: The sweep visits one frame per cycle starting in the cycle after the request; a visited frame with the reference flag at 1 has it cleared and its counter decremented if nonzero; a frame with the flag at 0 and a nonzero counter has the counter decremented; the hand then moves to the next frame, wrapping from the last frame to frame 0.
- R7: The first visited frame with reference flag 0 and counter 0 is the victim: done_o is high for exactly one cycle, the cycle after that visit, with victim_o holding its index; when the k-th visit selects it, done_o is seen k cycles after the request is sampled.
- R8: The next sweep starts at the frame after the last victim.
- R9: A victim request that arrives while a sweep is in progress is ignored and produces no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hit_v_i | input | 1 | Hit strobe |
| hit_page_i | input | PG_W | Frame index of the hit |
| hit_sub_i | input | SB_W | Sub-block index of the hit |
| hit_wr_i | input | 1 | 1 for a write hit, 0 for a read hit |
| ins_v_i | input | 1 | Insert (demotion) strobe |
| ins_page_i | input | PG_W | Frame that receives the demoted page |
| ins_ref_i | input | 1 | Reference flag carried by the demoted page |
| find_i | input | 1 | Victim request |
| promote_o | output | 1 | Temporal-locality promotion pulse |
| promote_page_o | output | PG_W | Frame to promote, valid with promote_o |
| victim_o | output | PG_W | Selected victim frame, valid with done_o |
| done_o | output | 1 | Victim-found pulse |

## Verification
Every result is registered once, so a promotion pulse is due in the cycle after the hit is sampled and the done pulse is due k cycles after the request edge when the k-th visit finds the victim. The bench drives inputs on falling edges and reads outputs on the next falling edge, counting falling edges between the request and the done pulse to compare the visit count with the value worked out from the frame states it set up. Internal state is never read; it is inferred from which frame a sweep picks, how many visits it takes, and whether a repeated write promotes.

// File: rtl/pts_pkg.sv
package pts_pkg;
    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_st_e;
endpackage

// File: rtl/pts_page_store.sv
module pts_page_store #(
    parameter int NUM_PAGES  = 8,
    parameter int SUB_BLOCKS = 64,
    parameter int DC_W       = 8,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int SB_W      = $clog2(SUB_BLOCKS)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hit_v_i,
    input  logic [PG_W-1:0] hit_page_i,
    input  logic [SB_W-1:0] hit_sub_i,
    input  logic            hit_wr_i,
    input  logic            ins_v_i,
    input  logic [PG_W-1:0] ins_page_i,
    input  logic            ins_ref_i,
    input  logic            step_v_i,
    input  logic [PG_W-1:0] vis_page_i,
    output logic            vis_ref_o,
    output logic            vis_dc_zero_o,
    output logic            promote_o,
    output logic [PG_W-1:0] promote_page_o
);
    localparam logic [DC_W-1:0] DC_MAX = {DC_W{1'b1}};

    typedef struct packed {
        logic [NUM_PAGES-1:0]                 ref_bits;
        logic [NUM_PAGES-1:0][SUB_BLOCKS-1:0] bd;
        logic [NUM_PAGES-1:0][DC_W-1:0]       dc;
        logic                                 promote;
        logic [PG_W-1:0]                      promote_pg;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.promote = 1'b0;
        if (hit_v_i) begin
            s_d.ref_bits[hit_page_i] = 1'b1;
            if (hit_wr_i) begin
                if (s_q.bd[hit_page_i][hit_sub_i]) begin
                    s_d.promote    = 1'b1;
                    s_d.promote_pg = hit_page_i;
                end else begin
                    s_d.bd[hit_page_i][hit_sub_i] = 1'b1;
                    if (s_q.dc[hit_page_i] != DC_MAX)
                        s_d.dc[hit_page_i] = s_q.dc[hit_page_i] + 1'b1;
                end
            end
        end
        if (step_v_i) begin
            s_d.ref_bits[vis_page_i] = 1'b0;
            if (s_q.dc[vis_page_i] != '0)
                s_d.dc[vis_page_i] = s_q.dc[vis_page_i] - 1'b1;
        end
        if (ins_v_i) begin
            s_d.ref_bits[ins_page_i] = ins_ref_i;
            s_d.bd[ins_page_i]       = '0;
            s_d.dc[ins_page_i]       = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign vis_ref_o      = s_q.ref_bits[vis_page_i];
    assign vis_dc_zero_o  = (s_q.dc[vis_page_i] == '0);
    assign promote_o      = s_q.promote;
    assign promote_page_o = s_q.promote_pg;

    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_chk
            // R3
            dc_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                32'(s_q.dc[p]) <= $countones(s_q.bd[p]));
        end
    endgenerate

    // R4
    promote_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_v_i && hit_wr_i && s_q.bd[hit_page_i][hit_sub_i]
        |=> promote_o && promote_page_o == $past(hit_page_i));

    // R5
    insert_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_v_i |=> s_q.dc[$past(ins_page_i)] == '0 && s_q.bd[$past(ins_page_i)] == '0);
endmodule

// File: rtl/pts_sweep_ctrl.sv
module pts_sweep_ctrl
    import pts_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            find_i,
    input  logic            stall_i,
    input  logic            vis_ref_i,
    input  logic            vis_dc_zero_i,
    output logic            step_v_o,
    output logic [PG_W-1:0] hand_o,
    output logic [PG_W-1:0] victim_o,
    output logic            done_o
);
    localparam logic [PG_W-1:0] LAST_PG = PG_W'(NUM_PAGES - 1);

    typedef struct packed {
        sweep_st_e       st;
        logic [PG_W-1:0] hand;
        logic [PG_W-1:0] victim;
        logic            done;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  pick;
    logic [PG_W-1:0] hand_nx;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        step_v_o = 1'b0;
        pick     = !vis_ref_i && vis_dc_zero_i;
        hand_nx  = (c_q.hand == LAST_PG) ? '0 : c_q.hand + 1'b1;
        unique case (c_q.st)
            SWEEP_IDLE: if (find_i) c_d.st = SWEEP_RUN;
            SWEEP_RUN: begin
                if (!stall_i) begin
                    c_d.hand = hand_nx;
                    if (pick) begin
                        c_d.done   = 1'b1;
                        c_d.victim = c_q.hand;
                        c_d.st     = SWEEP_IDLE;
                    end else begin
                        step_v_o = 1'b1;
                    end
                end
            end
            default: c_d.st = SWEEP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) c_q <= '{st: SWEEP_IDLE, hand: '0, victim: '0, done: 1'b0};
        else         c_q <= c_d;
    end

    assign hand_o   = c_q.hand;
    assign victim_o = c_q.victim;
    assign done_o   = c_q.done;

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    victim_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(!vis_ref_i && vis_dc_zero_i));

    // R6
    hand_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(hand_o) < NUM_PAGES);
endmodule

// File: rtl/pcm_page_tracker.sv
module pcm_page_tracker #(
    parameter int NUM_PAGES  = 8,
    parameter int SUB_BLOCKS = 64,
    parameter int DC_W       = 8,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int SB_W      = $clog2(SUB_BLOCKS)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hit_v_i,
    input  logic [PG_W-1:0] hit_page_i,
    input  logic [SB_W-1:0] hit_sub_i,
    input  logic            hit_wr_i,
    input  logic            ins_v_i,
    input  logic [PG_W-1:0] ins_page_i,
    input  logic            ins_ref_i,
    input  logic            find_i,
    output logic            promote_o,
    output logic [PG_W-1:0] promote_page_o,
    output logic [PG_W-1:0] victim_o,
    output logic            done_o
);
    logic            step_v;
    logic [PG_W-1:0] hand;
    logic            vis_ref;
    logic            vis_dc_zero;
    logic            stall;

    assign stall = hit_v_i || ins_v_i;

    pts_page_store #(
        .NUM_PAGES (NUM_PAGES),
        .SUB_BLOCKS(SUB_BLOCKS),
        .DC_W      (DC_W)
    ) u_store (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .hit_v_i       (hit_v_i),
        .hit_page_i    (hit_page_i),
        .hit_sub_i     (hit_sub_i),
        .hit_wr_i      (hit_wr_i),
        .ins_v_i       (ins_v_i),
        .ins_page_i    (ins_page_i),
        .ins_ref_i     (ins_ref_i),
        .step_v_i      (step_v),
        .vis_page_i    (hand),
        .vis_ref_o     (vis_ref),
        .vis_dc_zero_o (vis_dc_zero),
        .promote_o     (promote_o),
        .promote_page_o(promote_page_o)
    );

    pts_sweep_ctrl #(
        .NUM_PAGES(NUM_PAGES)
    ) u_sweep (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .find_i       (find_i),
        .stall_i      (stall),
        .vis_ref_i    (vis_ref),
        .vis_dc_zero_i(vis_dc_zero),
        .step_v_o     (step_v),
        .hand_o       (hand),
        .victim_o     (victim_o),
        .done_o       (done_o)
    );

    // R4
    promote_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        promote_o |-> $past(hit_v_i && hit_wr_i));
endmodule

// File: tb/tb_pcm_page_tracker.sv
module tb_pcm_page_tracker;
    localparam int N    = 8;
    localparam int SB   = 64;
    localparam int PG_W = $clog2(N);
    localparam int SB_W = $clog2(SB);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hit_v = 1'b0;
    logic [PG_W-1:0] hit_page = '0;
    logic [SB_W-1:0] hit_sub = '0;
    logic            hit_wr = 1'b0;
    logic            ins_v = 1'b0;
    logic [PG_W-1:0] ins_page = '0;
    logic            ins_ref = 1'b0;
    logic            find = 1'b0;
    logic            promote;
    logic [PG_W-1:0] promote_page;
    logic [PG_W-1:0] victim;
    logic            done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pcm_page_tracker #(.NUM_PAGES(N), .SUB_BLOCKS(SB), .DC_W(8)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .hit_v_i(hit_v), .hit_page_i(hit_page), .hit_sub_i(hit_sub), .hit_wr_i(hit_wr),
        .ins_v_i(ins_v), .ins_page_i(ins_page), .ins_ref_i(ins_ref),
        .find_i(find),
        .promote_o(promote), .promote_page_o(promote_page),
        .victim_o(victim), .done_o(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one hit, then checks the promotion outcome in the following cycle
    task automatic do_hit(input int pg, input int sb, input bit wr,
                          input bit exp_prom, input string req);
        @(negedge clk);
        hit_v = 1'b1; hit_page = PG_W'(pg); hit_sub = SB_W'(sb); hit_wr = wr;
        @(negedge clk);
        hit_v = 1'b0; hit_wr = 1'b0;
        check(req, int'(promote), int'(exp_prom));
        if (exp_prom) begin
            check(req, int'(promote_page), pg);
            @(negedge clk);
            check(req, int'(promote), 0);
        end
    endtask

    task automatic do_insert(input int pg, input bit rf);
        @(negedge clk);
        ins_v = 1'b1; ins_page = PG_W'(pg); ins_ref = rf;
        @(negedge clk);
        ins_v = 1'b0;
    endtask

    // request a victim; optionally re-request during the sweep
    task automatic sweep(input int exp_victim, input int exp_visits,
                         input string req, input int extra_req_at);
        int n = 0;
        @(negedge clk);
        find = 1'b1;
        @(negedge clk);
        find = 1'b0;
        while (n < 300) begin
            @(negedge clk);
            n++;
            find = (n == extra_req_at);
            if (done) break;
        end
        find = 1'b0;
        check(req, int'(victim), exp_victim);
        check(req, n, exp_visits);
        @(negedge clk);
        check(req, int'(done), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", int'(done), 0);
        check("R1", int'(promote), 0);
        sweep(0, 1, "R1", 0);
    endtask

    task automatic t_locality;
        // R2: read sub 5 of page 2 leaves it clean, write then is spatial
        do_hit(2, 5, 1'b0, 1'b0, "R2");
        do_hit(2, 5, 1'b1, 1'b0, "R3");
        do_hit(2, 6, 1'b1, 1'b0, "R3");
        do_hit(2, 7, 1'b1, 1'b0, "R3");
        // R4: repeated write to dirty sub-block promotes page 2
        do_hit(2, 6, 1'b1, 1'b1, "R4");
        do_hit(1, 0, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_sweeps;
        // R6: hand at 1; page1 ref only, page2 ref+dc3, page3 clean
        sweep(3, 3, "R6", 0);
        // R8: continues at page 4
        sweep(4, 1, "R8", 0);
        // R7: wrap; pages 5,6,7,0 referenced, page1 now clean
        do_hit(5, 0, 1'b0, 1'b0, "R2");
        do_hit(6, 0, 1'b0, 1'b0, "R2");
        do_hit(7, 0, 1'b0, 1'b0, "R2");
        do_hit(0, 0, 1'b0, 1'b0, "R2");
        sweep(1, 5, "R7", 0);
        // R6: page2 ref 0 dc 2 -> decrement and skip; page3 clean
        sweep(3, 2, "R6", 0);
        // R7/R9: all referenced, full lap then page 4; extra request ignored
        for (int p = 0; p < N; p++) do_hit(p, 1, 1'b0, 1'b0, "R2");
        sweep(4, 9, "R9", 3);
        repeat (12) begin
            @(negedge clk);
            check("R9", int'(done), 0);
        end
    endtask

    task automatic t_insert;
        // R5: insert with reference set is skipped once
        do_insert(5, 1'b1);
        sweep(6, 2, "R5", 0);
        // R5: dirty page 7, insert clean, then it is an immediate victim
        do_hit(7, 3, 1'b1, 1'b0, "R3");
        do_insert(7, 1'b0);
        sweep(7, 1, "R5", 0);
        // R5: bitmap cleared, so writing sub 3 again does not promote
        do_hit(7, 3, 1'b1, 1'b0, "R5");
        do_hit(7, 3, 1'b1, 1'b1, "R4");
        // R5: insert wins over same-cycle hit to the same frame
        @(negedge clk);
        hit_v = 1'b1; hit_page = 3'(0); hit_sub = '0; hit_wr = 1'b1;
        ins_v = 1'b1; ins_page = 3'(0); ins_ref = 1'b0;
        @(negedge clk);
        hit_v = 1'b0; ins_v = 1'b0; hit_wr = 1'b0;
        do_hit(0, 0, 1'b1, 1'b0, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locality();
        t_sweeps();
        t_insert();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule